// File: doc/BRIEF.md
# Multi-cycle load-store processor core

This block is a small non-pipelined 32-bit processor core. It runs one instruction at a time. Each instruction passes through a fixed schedule of steps: fetch, decode with register read, execute, memory and write-back. Between steps, results are held in dedicated latches: the instruction word, the next sequential PC, two operand values, a sign-extended immediate, the ALU result, a branch condition flag and the loaded data. The core supports a small instruction subset:

- a word load and a word store;
- register-register ALU operations;
- register-immediate ALU operations;
- a branch taken when one register equals zero.

Only the load and the store touch data memory.

The core reads instructions through a combinational word-wide instruction port. It reads and writes data through a combinational data port that has an address, write data, a write strobe and read data. A debug port shows the current PC and every register-file write in the cycle it is made. Stores, branches and no-ops retire after four cycles. Loads and ALU operations retire after five.

Top module: `mc_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the PC to 0 and returns the step sequence to fetch. While reset holds, neither the register-write strobe nor the data write strobe is asserted.
- R2: In the fetch step, `imem_addr` equals the PC. The instruction word is latched and the next sequential PC is set to PC + 4.
- R3: The instruction fields are: opcode in bits 31..26, source register rs in 25..21, second register rt in 20..16, destination rd in 15..11, shift amount in 10..6, function code in 5..0, and immediate in 15..0. The immediate is always sign-extended from bit 15. The effective address of a load or store is rs + immediate.
- R4: Opcode 0x00 selects a register-register operation, with a shift amount of 0 and one of these function codes: 0x20 add, 0x22 subtract (rs - rt), 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than. The result is written to rd in the fifth cycle.
- R5: These opcodes apply an operation to rs and the sign-extended immediate and write the result to rt in the fifth cycle: 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or, 0x0E xor.
- R6: Load (opcode 0x23) reads the data word at the effective address and writes it to rt in the fifth cycle.
- R7: Store (opcode 0x2B) writes rt to the effective address with exactly one `dmem_we` pulse, in the fourth cycle. It makes no register write and takes four cycles. No other instruction asserts `dmem_we`.
- R8: Branch-if-zero (opcode 0x04) tests rs. If rs is zero, the PC becomes PC + 4 + (immediate << 2); otherwise it becomes PC + 4. It takes four cycles. No instruction changes the PC before the end of its fourth cycle.
- R9: Register 0 always reads as zero. A write aimed at it is dropped, and no debug write is shown for it.
- R10: Any other opcode or function code, or a nonzero shift amount, executes as a four-cycle no-op. It advances the PC by 4 and writes neither registers nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Instruction fetch byte address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe, one cycle per store |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |
| dbg_pc | output | 32 | Current PC |
| dbg_we | output | 1 | Register write occurring this cycle |
| dbg_widx | output | 5 | Register index being written |
| dbg_wdata | output | 32 | Value being written |

## Verification
The main function is exercised by a straight-line program trace that covers every instruction class:

- Loads of a positive and a negative word separate sign handling in the later set-less-than and subtraction results.
- Immediates of 0xFFFF, 0xFFF1, 0xFFF8 and 0x8000 catch any zero-extension in the arithmetic, compare, address and logical paths.
- One branch tests a register holding 1, and two branches test registers holding zero. These tell a taken redirect from a fall-through, and the branch target from the next sequential address.
- Instructions aimed at register 0, an unknown opcode carrying a nonzero rt, and a store of register 0 show that dropped writes and no-ops leave no trace.
- A load that rereads a stored word confirms the store's address and data together.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEM    = 3'd3,
        ST_WB     = 3'd4
    } step_e;

    typedef enum logic [2:0] {
        K_NOP   = 3'd0,
        K_LOAD  = 3'd1,
        K_STORE = 3'd2,
        K_RR    = 3'd3,
        K_RI    = 3'd4,
        K_BRZ   = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4,
        ALU_SLT = 3'd5
    } alu_op_e;

    typedef struct packed {
        kind_e       kind;
        alu_op_e     op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  dst;
        logic [15:0] imm;
    } dec_t;

    localparam logic [5:0] OPC_RR    = 6'h00;
    localparam logic [5:0] OPC_BRZ   = 6'h04;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_SLTI  = 6'h0A;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_pkg::*;
(
    input  logic [31:0] ir,
    output dec_t        dec
);
    logic [5:0] opc;
    logic [5:0] fn;

    always_comb begin
        opc      = ir[31:26];
        fn       = ir[5:0];
        dec.kind = K_NOP;
        dec.op   = ALU_ADD;
        dec.rs   = ir[25:21];
        dec.rt   = ir[20:16];
        dec.dst  = 5'd0;
        dec.imm  = ir[15:0];
        case (opc)
            OPC_RR: begin
                if (ir[10:6] == 5'd0) begin
                    dec.kind = K_RR;
                    dec.dst  = ir[15:11];
                    case (fn)
                        FN_ADD:  dec.op = ALU_ADD;
                        FN_SUB:  dec.op = ALU_SUB;
                        FN_AND:  dec.op = ALU_AND;
                        FN_OR:   dec.op = ALU_OR;
                        FN_XOR:  dec.op = ALU_XOR;
                        FN_SLT:  dec.op = ALU_SLT;
                        default: begin
                            dec.kind = K_NOP;
                            dec.dst  = 5'd0;
                        end
                    endcase
                end
            end
            OPC_LOAD: begin
                dec.kind = K_LOAD;
                dec.dst  = ir[20:16];
            end
            OPC_STORE: dec.kind = K_STORE;
            OPC_BRZ:   dec.kind = K_BRZ;
            OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_XORI: begin
                dec.kind = K_RI;
                dec.dst  = ir[20:16];
                case (opc)
                    OPC_SLTI: dec.op = ALU_SLT;
                    OPC_ANDI: dec.op = ALU_AND;
                    OPC_ORI:  dec.op = ALU_OR;
                    OPC_XORI: dec.op = ALU_XOR;
                    default:  dec.op = ALU_ADD;
                endcase
            end
            default: dec.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RIDX-1:0] ra1,
    input  logic [RIDX-1:0] ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [RIDX-1:0] wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs_q [1:NREG-1];
    logic [XLEN-1:0] regs_d [1:NREG-1];

    for (genvar gi = 1; gi < NREG; gi++) begin : g_word
        always_comb begin
            regs_d[gi] = regs_q[gi];
            if (we && (wa == RIDX'(gi))) begin
                regs_d[gi] = wd;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[gi] <= '0;
            end else begin
                regs_q[gi] <= regs_d[gi];
            end
        end
    end

    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
        rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (regs_q[$past(wa)] == $past(wd))); // R4
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [XLEN-1:0] dbg_pc,
    output logic            dbg_we,
    output logic [4:0]      dbg_widx,
    output logic [XLEN-1:0] dbg_wdata
);
    localparam int NREG = 32;
    localparam int IMM_PAD = XLEN - 16;

    typedef struct packed {
        step_e           step;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [31:0]     ir;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] imm;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] lmd;
        logic            cond;
    } state_t;

    state_t          s_d, s_q;
    dec_t            dec;
    logic [XLEN-1:0] rf_rd1, rf_rd2;
    logic            rf_we;
    logic [XLEN-1:0] rf_wd;
    logic [XLEN-1:0] alu_a, alu_b, alu_y;
    alu_op_e         alu_op;

    mc_decode u_dec (
        .ir  (s_q.ir),
        .dec (dec)
    );

    mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (dec.rs),
        .ra2 (dec.rt),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2),
        .we  (rf_we),
        .wa  (dec.dst),
        .wd  (rf_wd)
    );

    mc_alu #(.XLEN(XLEN)) u_alu (
        .a  (alu_a),
        .b  (alu_b),
        .op (alu_op),
        .y  (alu_y)
    );

    always_comb begin
        s_d     = s_q;
        rf_we   = 1'b0;
        rf_wd   = (dec.kind == K_LOAD) ? s_q.lmd : s_q.alu;
        dmem_we = 1'b0;
        alu_a   = s_q.a;
        alu_b   = s_q.imm;
        alu_op  = ALU_ADD;
        case (dec.kind)
            K_RR:  begin alu_b = s_q.b; alu_op = dec.op; end
            K_RI:  alu_op = dec.op;
            K_BRZ: begin alu_a = s_q.npc; alu_b = s_q.imm << 2; end
            default: ;
        endcase

        case (s_q.step)
            ST_FETCH: begin
                s_d.ir   = imem_rdata;
                s_d.npc  = s_q.pc + XLEN'(4);
                s_d.step = ST_DECODE;
            end
            ST_DECODE: begin
                s_d.a    = rf_rd1;
                s_d.b    = rf_rd2;
                s_d.imm  = {{IMM_PAD{dec.imm[15]}}, dec.imm};
                s_d.step = ST_EXEC;
            end
            ST_EXEC: begin
                if (dec.kind != K_NOP) begin
                    s_d.alu = alu_y;
                end
                if (dec.kind == K_BRZ) begin
                    s_d.cond = (s_q.a == '0);
                end
                s_d.step = ST_MEM;
            end
            ST_MEM: begin
                if (dec.kind == K_LOAD) begin
                    s_d.lmd = dmem_rdata;
                end
                dmem_we = (dec.kind == K_STORE);
                s_d.pc  = (dec.kind == K_BRZ && s_q.cond) ? s_q.alu : s_q.npc;
                if (dec.kind inside {K_LOAD, K_RR, K_RI}) begin
                    s_d.step = ST_WB;
                end else begin
                    s_d.step = ST_FETCH;
                end
            end
            default: begin
                rf_we    = (dec.dst != 5'd0);
                s_d.step = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_addr  = s_q.pc;
    assign dmem_addr  = s_q.alu;
    assign dmem_wdata = s_q.b;
    assign dbg_pc     = s_q.pc;
    assign dbg_we     = rf_we;
    assign dbg_widx   = dec.dst;
    assign dbg_wdata  = rf_wd;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (s_q.pc == '0 && s_q.step == ST_FETCH && !dbg_we && !dmem_we)); // R1
    AST_FETCH_LATCH: assert property (@(posedge clk) disable iff (rst)
        (s_q.step == ST_FETCH) |=> (s_q.step == ST_DECODE && s_q.ir == $past(imem_rdata)
                                    && s_q.npc == $past(s_q.pc) + XLEN'(4))); // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_q.step != ST_MEM) |=> $stable(s_q.pc)); // R8
    AST_STORE_ONLY_WRITES: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (s_q.step == ST_MEM && dec.kind == K_STORE)); // R7
    AST_SHORT_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (s_q.step == ST_MEM && dec.kind inside {K_STORE, K_BRZ, K_NOP})
            |=> (s_q.step == ST_FETCH)); // R10
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (s_q.step == ST_EXEC && dec.rs == 5'd0) |-> (s_q.a == '0)); // R9
endmodule

// File: tb/sim_mc_core.sv
module sim_mc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] dbg_pc, dbg_wdata;
    logic        dbg_we;
    logic [4:0]  dbg_widx;

    int checks = 0;
    int fails  = 0;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    always #10 clk = ~clk;

    mc_core u0 (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
        .dbg_pc(dbg_pc), .dbg_we(dbg_we), .dbg_widx(dbg_widx), .dbg_wdata(dbg_wdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    typedef struct packed {
        logic [31:0] pc;
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [15:0] imm;
        logic [2:0]  cyc;
        logic        we;
        logic [4:0]  widx;
        logic [31:0] wdata;
        logic [31:0] npc;
        logic        mw;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{32'h00, 6'h08, 5'd0, 5'd1,  16'h0010,          3'd5, 1'b1, 5'd1,  32'h00000010, 32'h04, 1'b0},
        '{32'h04, 6'h23, 5'd1, 5'd2,  16'h0000,          3'd5, 1'b1, 5'd2,  32'h00001234, 32'h08, 1'b0},
        '{32'h08, 6'h23, 5'd1, 5'd3,  16'h0004,          3'd5, 1'b1, 5'd3,  32'hFFFFFFF0, 32'h0C, 1'b0},
        '{32'h0C, 6'h00, 5'd2, 5'd3,  {5'd4,  11'h020},  3'd5, 1'b1, 5'd4,  32'h00001224, 32'h10, 1'b0},
        '{32'h10, 6'h00, 5'd2, 5'd3,  {5'd5,  11'h022},  3'd5, 1'b1, 5'd5,  32'h00001244, 32'h14, 1'b0},
        '{32'h14, 6'h00, 5'd3, 5'd2,  {5'd6,  11'h02A},  3'd5, 1'b1, 5'd6,  32'h00000001, 32'h18, 1'b0},
        '{32'h18, 6'h08, 5'd0, 5'd7,  16'hFFFF,          3'd5, 1'b1, 5'd7,  32'hFFFFFFFF, 32'h1C, 1'b0},
        '{32'h1C, 6'h2B, 5'd1, 5'd4,  16'h0008,          3'd4, 1'b0, 5'd0,  32'h0,        32'h20, 1'b1},
        '{32'h20, 6'h04, 5'd6, 5'd0,  16'h0003,          3'd4, 1'b0, 5'd0,  32'h0,        32'h24, 1'b0},
        '{32'h24, 6'h04, 5'd0, 5'd0,  16'h0002,          3'd4, 1'b0, 5'd0,  32'h0,        32'h30, 1'b0},
        '{32'h30, 6'h08, 5'd0, 5'd0,  16'h0005,          3'd5, 1'b0, 5'd0,  32'h0,        32'h34, 1'b0},
        '{32'h34, 6'h00, 5'd0, 5'd0,  {5'd8,  11'h020},  3'd5, 1'b1, 5'd8,  32'h00000000, 32'h38, 1'b0},
        '{32'h38, 6'h3F, 5'd1, 5'd2,  16'h1234,          3'd4, 1'b0, 5'd0,  32'h0,        32'h3C, 1'b0},
        '{32'h3C, 6'h00, 5'd4, 5'd7,  {5'd9,  11'h026},  3'd5, 1'b1, 5'd9,  32'hFFFFEDDB, 32'h40, 1'b0},
        '{32'h40, 6'h0C, 5'd7, 5'd10, 16'h00F0,          3'd5, 1'b1, 5'd10, 32'h000000F0, 32'h44, 1'b0},
        '{32'h44, 6'h0D, 5'd2, 5'd11, 16'h8000,          3'd5, 1'b1, 5'd11, 32'hFFFF9234, 32'h48, 1'b0},
        '{32'h48, 6'h2B, 5'd1, 5'd0,  16'hFFF8,          3'd4, 1'b0, 5'd0,  32'h0,        32'h4C, 1'b1},
        '{32'h4C, 6'h04, 5'd8, 5'd0,  16'h0001,          3'd4, 1'b0, 5'd0,  32'h0,        32'h54, 1'b0},
        '{32'h54, 6'h00, 5'd9, 5'd11, {5'd12, 11'h024},  3'd5, 1'b1, 5'd12, 32'hFFFF8010, 32'h58, 1'b0},
        '{32'h58, 6'h00, 5'd2, 5'd10, {5'd13, 11'h025},  3'd5, 1'b1, 5'd13, 32'h000012F4, 32'h5C, 1'b0},
        '{32'h5C, 6'h0A, 5'd3, 5'd14, 16'hFFF1,          3'd5, 1'b1, 5'd14, 32'h00000001, 32'h60, 1'b0},
        '{32'h60, 6'h23, 5'd1, 5'd15, 16'h0008,          3'd5, 1'b1, 5'd15, 32'h00001224, 32'h64, 1'b0},
        '{32'h64, 6'h0E, 5'd13, 5'd16, 16'h00FF,         3'd5, 1'b1, 5'd16, 32'h0000120B, 32'h68, 1'b0},
        '{32'h68, 6'h00, 5'd0, 5'd1,  {5'd17, 11'h022},  3'd5, 1'b1, 5'd17, 32'hFFFFFFF0, 32'h6C, 1'b0}
    };

    function automatic string tag_of(vec_t v);
        if (v.op == 6'h00 && v.rs == 5'd0 && v.rt == 5'd0) return "R9";
        if (v.op == 6'h08 && v.rt == 5'd0) return "R9";
        case (v.op)
            6'h00: return "R4";
            6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E: return "R5";
            6'h23: return "R6";
            6'h2B: return "R7";
            6'h04: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int nwe, nmw;
        logic [4:0]  gidx;
        logic [31:0] gdat;
        bit held;
        for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
        for (int i = 0; i < NV; i++) imem[TBL[i].pc[7:2]] = {TBL[i].op, TBL[i].rs, TBL[i].rt, TBL[i].imm};
        imem[6'h0A] = {6'h08, 5'd0, 5'd9, 16'd99};
        imem[6'h0B] = {6'h08, 5'd0, 5'd9, 16'd99};
        imem[6'h14] = {6'h08, 5'd0, 5'd9, 16'd99};
        dmem[2] = 32'h0000DEAD;
        dmem[4] = 32'h00001234;
        dmem[5] = 32'hFFFFFFF0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dbg_pc == 0 && imem_addr == 0, "R1", "pc after reset", dbg_pc, 32'h0);
        check(!dbg_we && !dmem_we, "R1", "strobes in reset", {30'h0, dbg_we, dmem_we}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            nwe = 0; nmw = 0; gidx = '0; gdat = '0; held = 1'b1;
            check(dbg_pc == TBL[i].pc && imem_addr == TBL[i].pc, "R2", "fetch address", imem_addr, TBL[i].pc);
            for (int c = 0; c < int'(TBL[i].cyc); c++) begin
                if (dbg_we) begin nwe++; gidx = dbg_widx; gdat = dbg_wdata; end
                if (dmem_we) nmw++;
                if (c <= 3 && dbg_pc != TBL[i].pc) held = 1'b0;
                @(negedge clk);
            end
            check(held, "R8", "pc held through fourth cycle", {31'h0, held}, 32'h1);
            check(nwe == int'(TBL[i].we) && (!TBL[i].we || (gidx == TBL[i].widx && gdat == TBL[i].wdata)),
                  tag_of(TBL[i]), $sformatf("register write at pc %h", TBL[i].pc),
                  gdat, TBL[i].wdata);
            check(nmw == int'(TBL[i].mw), (TBL[i].mw ? "R7" : "R10"), "data write strobes",
                  nmw, {31'h0, TBL[i].mw});
            check(dbg_pc == TBL[i].npc, tag_of(TBL[i]), "next pc after retire", dbg_pc, TBL[i].npc);
        end

        // R7 store contents; R3 negative store offset; R10 nop left memory alone
        check(dmem[6] == 32'h00001224, "R7", "stored word", dmem[6], 32'h00001224);
        check(dmem[2] == 32'h0, "R3", "store at negative offset", dmem[2], 32'h0);
        check(dmem[4] == 32'h00001234, "R10", "untouched word", dmem[4], 32'h00001234);

        // R10: zero-filled word (opcode 0, function 0) is a four-cycle no-op
        repeat (4) @(negedge clk);
        check(dbg_pc == 32'h70, "R10", "zero word advances pc", dbg_pc, 32'h70);

        // R1: reset in the middle of an instruction
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(dbg_pc == 0 && !dbg_we && !dmem_we, "R1", "mid-run reset", dbg_pc, 32'h0);
        rst = 1'b0;
        nwe = 0; gdat = '0;
        for (int c = 0; c < 5; c++) begin
            if (dbg_we) begin nwe++; gdat = dbg_wdata; end
            @(negedge clk);
        end
        check(nwe == 1 && gdat == 32'h10 && dbg_pc == 32'h4, "R1", "restart from zero", gdat, 32'h10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule